// File: doc/BRIEF.md
# Uniform-Constant Request Serializer

This block takes one read request from a 32-lane warp aimed at a read-only constant space. Each lane supplies an active flag and a word address. The warp is split into a low half (lanes 0..15) and a high half (lanes 16..31). Each half is run as its own sub-request, the low half first. Within a half, the block walks the active lanes from the lowest index upward and picks the next address that is still unserved. It performs one backend read for that address and hands the word to every pending lane of that half that asked for it. The request therefore costs one backend read per distinct address in each half, and a half whose active lanes all share one address costs a single read.

The backend is a direct-mapped cache of single-word lines. A hit answers in the same cycle it is looked up. A miss drives a fixed-latency memory port for a set number of cycles, samples the memory word, writes it into the line and delivers it. The request side is a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and the request inputs are ignored at all other times. Results stay on `resp_data` from the `done` pulse until the next request is taken.

Top module: `ucs_top`

## Requirements
- R1: `req_ready` is high exactly while idle. A request is captured only on an edge with `req_valid` and `req_ready` both high. Changes to `req_valid`, `req_active` or `req_addr` while busy have no effect on the result. `mem_req` is never high while `req_ready` is high.
- R2: The low half (lanes 0..15) is served completely before any backend read for the high half (lanes 16..31) begins.
- R3: Within a half, exactly one backend read is made per distinct address among its active lanes. The same address used in both halves is read once per half.
- R4: A miss holds `mem_req` high for exactly MEM_LAT (8) consecutive cycles with `mem_addr` stable. `mem_rdata` is sampled in the last of those cycles and written into the cache line.
- R5: If the accepting edge is number 0, `done` is first high after edge K. K = (sum over both halves of 1 per hit read and 1+MEM_LAT per miss read) + 2.
- R6: Within a half, distinct addresses are read in order of the lowest lane index that uses each one.
- R7: Inactive lanes receive all-zero data. A request with no active lanes completes with K = 2.
- R8: Every active lane receives the memory word at its own address.
- R9: `done` is high for one cycle per request. `resp_data` holds its value from `done` until the next accepted request.
- R10: The cache has 16 one-word lines, indexed by `addr[3:0]` and tagged by the upper address bits. All lines are invalid after reset, so the first read of any address after reset is a miss, and a read at the same index with another tag replaces the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_active | input | LANES | Per-lane active flags |
| req_addr | input | LANES x AW | Per-lane word addresses |
| resp_data | output | LANES x DW | Per-lane returned words |
| done | output | 1 | One-cycle pulse when all active lanes are served |
| mem_req | output | 1 | Memory read in progress (held for the miss latency) |
| mem_addr | output | AW | Address of the memory read |
| mem_rdata | input | DW | Memory word, sampled in the last cycle of `mem_req` |

## Verification
The main function is exercised with several address patterns:
- A warp-wide broadcast, which separates one read per half from one read per request and from one read per lane.
- Fully distinct addresses whose halves collide on the same cache index, which exercises eviction between the halves.
- Reversed modulo patterns with duplicates, which expose the lowest-lane ordering in the sequence of memory addresses.
- An empty request.
- A sweep over stride, offset, address range and active-mask shape, with the cache kept warm across requests.

For every request the bench checks the latency, the sequence of miss addresses and the data in each lane against its own cache model. Scrambling the inputs while the block is busy, and repeating a request after a second reset, separate correct input capture and valid clearing from stale state.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MISS = 2'd2
  } ucs_state_e;
endpackage

// File: rtl/ucs_lane_pick.sv
module ucs_lane_pick #(
  parameter int N  = 16,
  parameter int AW = 8
) (
  input  logic [N-1:0]         pend,
  input  logic [N-1:0][AW-1:0] addr,
  output logic                 any,
  output logic [AW-1:0]        lead,
  output logic [N-1:0]         match
);
  logic found;

  always_comb begin
    lead  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !found) begin
        lead  = addr[i];
        found = 1'b1;
      end
    end
  end

  assign any = |pend;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = pend[g] && (addr[g] == lead);
  end
endmodule

// File: rtl/ucs_cache.sv
module ucs_cache #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  input  logic          fill_en,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  logic [LINES-1:0] vld_q;
  logic [TW-1:0]    tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES];

  logic [IW-1:0] lk_idx, fl_idx;
  assign lk_idx  = lk_addr[IW-1:0];
  assign fl_idx  = fill_addr[IW-1:0];
  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_addr[AW-1:IW]);
  assign lk_data = dat_q[lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (fill_en) begin
      vld_q[fl_idx] <= 1'b1;
      tag_q[fl_idx] <= fill_addr[AW-1:IW];
      dat_q[fl_idx] <= fill_data;
    end
  end
endmodule

// File: rtl/ucs_top.sv
module ucs_top
  import ucs_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int LINES   = 16,
  parameter int MEM_LAT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES-1:0][AW-1:0] req_addr,
  output logic [LANES-1:0][DW-1:0] resp_data,
  output logic                    done,
  output logic                    mem_req,
  output logic [AW-1:0]           mem_addr,
  input  logic [DW-1:0]           mem_rdata
);
  localparam int HALF = LANES / 2;
  localparam int CW   = $clog2(MEM_LAT + 1);
  localparam logic [CW-1:0] CNT_END = CW'(MEM_LAT - 1);

  ucs_state_e               state_q;
  logic                     half_q;
  logic [LANES-1:0]         pend_q;
  logic [LANES-1:0][AW-1:0] addr_q;
  logic [LANES-1:0][DW-1:0] resp_q;
  logic                     done_q;
  logic [CW-1:0]            cnt_q;

  logic [HALF-1:0]          pend_h, match_h;
  logic [HALF-1:0][AW-1:0]  addr_h;
  logic                     any_h, hit;
  logic [AW-1:0]            lead;
  logic [DW-1:0]            cache_data, dval;
  logic                     miss_end, deliver;
  logic [LANES-1:0]         match_full;

  assign pend_h = half_q ? pend_q[LANES-1:HALF] : pend_q[HALF-1:0];
  assign addr_h = half_q ? addr_q[LANES-1:HALF] : addr_q[HALF-1:0];

  ucs_lane_pick #(.N(HALF), .AW(AW)) u_pick (
    .pend (pend_h),
    .addr (addr_h),
    .any  (any_h),
    .lead (lead),
    .match(match_h)
  );

  assign miss_end = (state_q == ST_MISS) && (cnt_q == CNT_END);

  ucs_cache #(.AW(AW), .DW(DW), .LINES(LINES)) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (lead),
    .lk_hit   (hit),
    .lk_data  (cache_data),
    .fill_en  (miss_end),
    .fill_addr(lead),
    .fill_data(mem_rdata)
  );

  assign deliver    = ((state_q == ST_LOOK) && any_h && hit) || miss_end;
  assign dval       = miss_end ? mem_rdata : cache_data;
  assign match_full = half_q ? {match_h, {HALF{1'b0}}} : {{HALF{1'b0}}, match_h};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= 1'b0;
      pend_q  <= '0;
      addr_q  <= '0;
      resp_q  <= '0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            pend_q  <= req_active;
            resp_q  <= '0;
            half_q  <= 1'b0;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!any_h) begin
            if (!half_q) begin
              half_q <= 1'b1;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (!hit) begin
            cnt_q   <= '0;
            state_q <= ST_MISS;
          end
        end
        ST_MISS: begin
          if (miss_end) state_q <= ST_LOOK;
          else          cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (deliver) begin
        pend_q <= pend_q & ~match_full;
        for (int i = 0; i < LANES; i++) begin
          if (match_full[i]) resp_q[i] <= dval;
        end
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign resp_data = resp_q;
  assign done      = done_q;
  assign mem_req   = (state_q == ST_MISS);
  assign mem_addr  = lead;
endmodule

// File: rtl/ucs_checker.sv
module ucs_checker #(
  parameter int LANES   = 32,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int MEM_LAT = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [LANES-1:0]         req_active,
  input logic [LANES-1:0][DW-1:0] resp_data,
  input logic                     done,
  input logic                     mem_req,
  input logic [AW-1:0]            mem_addr
);
  localparam int RW = $clog2(MEM_LAT + 2);

  logic [LANES-1:0] act_q, nz;
  logic [RW-1:0]    run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      run_q <= '0;
    end else begin
      if (req_valid && req_ready) act_q <= req_active;
      run_q <= mem_req ? run_q + 1'b1 : '0;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) nz[i] = |resp_data[i];
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_no_mem_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr));

  p_miss_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(run_q) < MEM_LAT));

  p_miss_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && run_q != '0) |-> (int'(run_q) == MEM_LAT));

  p_inactive_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((nz & ~act_q) == '0));
endmodule

bind ucs_top ucs_checker #(
  .LANES(LANES), .AW(AW), .DW(DW), .MEM_LAT(MEM_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_active(req_active),
  .resp_data (resp_data),
  .done      (done),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr)
);

// File: tb/ucs_top_bench.sv
`timescale 1ns/1ps
module ucs_top_bench;
  localparam int L   = 32;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int LAT = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [L-1:0]         req_active = '0;
  logic [L-1:0][AW-1:0] req_addr = '0;
  logic [L-1:0][DW-1:0] resp_data;
  logic                 done;
  logic                 mem_req;
  logic [AW-1:0]        mem_addr;
  logic [DW-1:0]        mem_rdata;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return 32'h5A00_0000 + DW'(a) * 32'h0001_0003;
  endfunction

  assign mem_rdata = memf(mem_addr);

  ucs_top u_ucs_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .resp_data(resp_data),
    .done(done), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  // miss log sampled away from the active edge
  logic [AW-1:0] log_a [64];
  int            nlog = 0;
  logic          mreq_prev = 1'b0;
  always @(negedge clk) begin
    if (mem_req && !mreq_prev && nlog < 64) begin
      log_a[nlog] = mem_addr;
      nlog = nlog + 1;
    end
    mreq_prev = mem_req;
  end

  // bench cache model
  logic [15:0]          bvld;
  logic [3:0]           btag [16];
  logic [L-1:0][DW-1:0] exp_resp;
  logic [AW-1:0]        exp_miss [64];
  int                   exp_n, exp_cost;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic model(input logic [L-1:0] act, input logic [L-1:0][AW-1:0] ad);
    exp_resp = '0;
    exp_n    = 0;
    exp_cost = 2;
    for (int h = 0; h < 2; h++) begin
      logic [15:0] pend;
      pend = act[h*16 +: 16];
      while (pend != 0) begin
        int j;
        logic [AW-1:0] a;
        j = 0;
        while (!pend[j]) j++;
        a = ad[h*16 + j];
        if (bvld[a[3:0]] && btag[a[3:0]] == a[7:4]) begin
          exp_cost += 1;
        end else begin
          exp_cost += 1 + LAT;
          exp_miss[exp_n] = a;
          exp_n++;
          bvld[a[3:0]] = 1'b1;
          btag[a[3:0]] = a[7:4];
        end
        for (int m = 0; m < 16; m++) begin
          if (pend[m] && ad[h*16 + m] == a) begin
            exp_resp[h*16 + m] = memf(a);
            pend[m] = 1'b0;
          end
        end
      end
    end
  endtask

  task automatic run_req(input logic [L-1:0] act, input logic [L-1:0][AW-1:0] ad,
                         input bit scramble, input string tag_lat);
    int k;
    int bad;
    bit ordok;
    logic [L-1:0][DW-1:0] snap;
    model(act, ad);
    @(negedge clk);
    nlog       = 0;
    req_valid  = 1'b1;
    req_active = act;
    req_addr   = ad;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      req_active = ~act;
      for (int i = 0; i < L; i++) req_addr[i] = ad[i] ^ 8'hA7;
      req_valid = 1'b1;
    end
    k = 0;
    while (k < 2000) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (done) break;
    end
    req_valid = 1'b0;
    chk(k == exp_cost, tag_lat, "latency", k, exp_cost);
    bad = 0;
    for (int i = 0; i < L; i++)
      if (act[i] && resp_data[i] != exp_resp[i]) bad++;
    chk(bad == 0, scramble ? "R1 R4 R8" : "R4 R8", "active lanes wrong", bad, 0);
    bad = 0;
    for (int i = 0; i < L; i++)
      if (!act[i] && resp_data[i] != '0) bad++;
    chk(bad == 0, "R7", "inactive lanes nonzero", bad, 0);
    chk(nlog == exp_n, "R3", "backend miss reads", nlog, exp_n);
    ordok = (nlog == exp_n);
    for (int i = 0; i < exp_n && i < nlog; i++)
      if (log_a[i] != exp_miss[i]) ordok = 1'b0;
    chk(ordok, "R2 R6", "miss address order", nlog, exp_n);
    snap = resp_data;
    @(negedge clk);
    chk(!done, "R9", "done longer than one cycle", done, 0);
    chk(resp_data == snap && req_ready, "R9", "result not held", req_ready, 1);
  endtask

  initial begin
    logic [L-1:0][AW-1:0] ad;
    logic [L-1:0]         act;
    bvld = '0;
    for (int i = 0; i < 16; i++) btag[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !mem_req && resp_data == '0, "R1",
        "reset state", {req_ready, done, mem_req}, 3'b100);

    // broadcast: one read per half, first one misses after reset
    for (int i = 0; i < L; i++) ad[i] = 8'h25;
    run_req('1, ad, 1'b0, "R5 R10");
    // same again: all hits
    run_req('1, ad, 1'b0, "R5");
    // distinct addresses, halves collide on index
    for (int i = 0; i < L; i++) ad[i] = AW'(i + 8'h40);
    run_req('1, ad, 1'b0, "R5");
    // empty request
    run_req('0, ad, 1'b0, "R7 R5");
    // reversed modulo pattern with duplicates
    for (int i = 0; i < L; i++) ad[i] = AW'(((31 - i) % 5) * 16 + 3);
    run_req(32'hF0F0_5A5A, ad, 1'b0, "R5 R6");
    // inputs scrambled while busy
    for (int i = 0; i < L; i++) ad[i] = AW'((i * 7) % 11 + 8'h80);
    run_req(32'h3C3C_FFFF, ad, 1'b1, "R1 R5");

    // sweep over stride, offset, range and mask shape
    for (int s = 1; s < 8; s += 2) begin
      for (int o = 0; o < 3; o++) begin
        for (int mr = 0; mr < 3; mr++) begin
          int mod;
          mod = (mr == 0) ? 4 : (mr == 1) ? 24 : 256;
          for (int i = 0; i < L; i++) ad[i] = AW'((i * s + o * 37) % mod);
          case ((s + o + mr) % 4)
            0: act = '1;
            1: act = 32'hAAAA_5555;
            2: act = 32'h0000_FFF1;
            default: act = 32'h8001_8001 << o;
          endcase
          run_req(act, ad, 1'b0, "R5");
        end
      end
    end

    // second reset clears the valid bits
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bvld = '0;
    for (int i = 0; i < L; i++) ad[i] = 8'h25;
    run_req('1, ad, 1'b0, "R10 R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule